// File: doc/BRIEF.md
# Serial Command Decoder for a Dual Digital Potentiometer

This block is the serial front end of a controller for two 64-step digital potentiometers. A host talks to it over a four-wire serial link that works like SPI mode 0. Data enters on the rising clock edge, and read data leaves on the falling edge. The front end samples the link pins into a faster system clock.

Each frame begins when chip select falls. The first byte is an identification byte, and the frame is accepted only if that byte carries the device type and the two address straps. The second byte is an instruction. The block turns the instruction into one of three things:
- a single command strobe towards the register file and the nonvolatile write controller;
- a read whose byte is shifted out on the serial output;
- an open-ended stream of up/down wiper steps.

A pause input can freeze a transfer half way without losing its place. A write-protect input blocks the commands that would write nonvolatile storage.

Top module: `potSpiDecoder`

## Requirements
- R1: Serial input is taken on rising serial-clock edges, most significant bit first. The first byte after chip select falls must equal `0101_00` followed by the two strap bits (bit 1 = strap[1], bit 0 = strap[0]). Any other first byte makes the block ignore the rest of the frame until chip select rises.
- R2: In the second byte, bits 7:4 are the opcode, bits 3:2 are the register index and bit 0 is the pot select. These fields appear on `cmdOp`, `cmdReg` and `cmdPot` once that byte has been received.
- R3: The transfer opcodes end after the instruction byte and give one `cmdValid` pulse. They are 1101 (register to wiper), 0001 (all registers to wipers), 1110 (wiper to register) and 1000 (all wipers to registers).
- R4: Write-wiper (1010) and write-register (1100) take a third byte. After its eighth bit they give one `cmdValid` pulse, with bits 5:0 of that byte on `cmdData`.
- R5: Read-wiper (1001) and read-register (1011) give one `cmdValid` fetch pulse after the instruction byte. The third byte then drives `{00, rdData}` on `soOut`, MSB first, with each bit updated after a falling serial-clock edge.
- R6: Read-status (0101) gives no strobe and shifts out `0000000` followed by `wipBit` in the LSB.
- R7: After opcode 0010, every rising serial-clock edge gives one `incStep` pulse, with `incUp` equal to the serial input at that edge. This continues until chip select rises.
- R8: While `wrProtN` is low, opcodes 1100, 1110 and 1000 give no strobe. Opcodes 1010 and 1101 are still accepted.
- R9: If chip select rises before a byte the command needs is complete, no strobe is given.
- R10: Pulling `holdN` low while the serial clock is low pauses the frame. Serial-clock edges are then ignored and `soOe` is low. Raising `holdN` while the serial clock is low resumes the frame where it stopped.
- R11: After reset, no frame is accepted until chip select has gone from high to low.
- R12: `soOe` is low whenever chip select is high. Opcodes not listed above give no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| csN | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| holdN | input | 1 | Pause request, active low |
| addrStrap | input | 2 | Device address straps |
| wrProtN | input | 1 | Nonvolatile write protect, active low |
| wipBit | input | 1 | Write-in-progress flag for status reads |
| rdData | input | 6 | Read data from the register file, valid the cycle after a fetch strobe |
| soOut | output | 1 | Serial data out |
| soOe | output | 1 | Output enable for the serial data out driver |
| cmdValid | output | 1 | One-cycle command strobe |
| cmdOp | output | 4 | Latched opcode |
| cmdReg | output | 2 | Latched register index |
| cmdPot | output | 1 | Latched pot select |
| cmdData | output | 6 | Write data for write commands |
| incStep | output | 1 | One-cycle wiper step strobe |
| incUp | output | 1 | Step direction, 1 = up |

## Verification
The situation hardest to reach is a pause in the middle of a read. The pause has to start while the serial clock is low and part of the byte has already been shifted out. Serial-clock edges then arrive that must be ignored, and after release the remaining bits must continue unbroken. The stimulus drives each serial bit from a task at a slow serial clock. Part way through the read byte it lowers the pause input and toggles the clock twice. It then releases the pause and checks that the reassembled byte is still exactly the register value. A frame sent right after reset with chip select already low checks the startup rule.

// File: rtl/potSpiPkg.sv
package potSpiPkg;
  localparam int BYTE_W = 8;
  localparam int DATA_W = 6;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ID, PH_INSTR, PH_WRDATA, PH_RDDATA, PH_STEP, PH_SKIP
  } phase_t;

  localparam logic [3:0] OP_RD_WCR     = 4'b1001;
  localparam logic [3:0] OP_WR_WCR     = 4'b1010;
  localparam logic [3:0] OP_RD_DR      = 4'b1011;
  localparam logic [3:0] OP_WR_DR      = 4'b1100;
  localparam logic [3:0] OP_DR2WCR     = 4'b1101;
  localparam logic [3:0] OP_WCR2DR     = 4'b1110;
  localparam logic [3:0] OP_STEP       = 4'b0010;
  localparam logic [3:0] OP_ALL_DR2WCR = 4'b0001;
  localparam logic [3:0] OP_ALL_WCR2DR = 4'b1000;
  localparam logic [3:0] OP_STATUS     = 4'b0101;

  localparam logic [5:0] ID_TYPE = 6'b010100;

  typedef struct packed {
    logic              clear;
    logic              sample;
    logic              launch;
    logic              loadTx;
    logic [BYTE_W-1:0] txWord;
  } pathCtl_t;
endpackage

// File: rtl/potSync.sv
module potSync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/potSpiPath.sv
module potSpiPath
  import potSpiPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pathCtl_t          ctl,
  input  logic              siBit,
  output logic [BYTE_W-1:0] rxNext,
  output logic              lastBit,
  output logic              soBit
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] txShift;
  logic [CNT_W-1:0]  bitCnt;

  assign rxNext  = {rxShift[BYTE_W-2:0], siBit};
  assign lastBit = (bitCnt == CNT_W'(BYTE_W - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '0;
      bitCnt  <= '0;
      soBit   <= 1'b0;
    end else begin
      if (ctl.clear) begin
        rxShift <= '0;
        bitCnt  <= '0;
      end else if (ctl.sample) begin
        rxShift <= rxNext;
        bitCnt  <= bitCnt + 1'b1;
      end
      if (ctl.loadTx) begin
        txShift <= ctl.txWord;
      end else if (ctl.launch) begin
        soBit   <= txShift[BYTE_W-1];
        txShift <= {txShift[BYTE_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/potSpiCtrl.sv
module potSpiCtrl
  import potSpiPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csS,
  input  logic              sckS,
  input  logic              siS,
  input  logic              holdS,
  input  logic [1:0]        addrStrap,
  input  logic              wrProtN,
  input  logic              wipBit,
  input  logic [DATA_W-1:0] rdData,
  input  logic [BYTE_W-1:0] rxNext,
  input  logic              lastBit,
  output pathCtl_t          ctl,
  output logic              soOe,
  output logic              cmdValid,
  output logic [3:0]        cmdOp,
  output logic [1:0]        cmdReg,
  output logic              cmdPot,
  output logic [DATA_W-1:0] cmdData,
  output logic              incStep,
  output logic              incUp
);
  phase_t phase;
  logic csPrev, sckPrev, paused, loadPend, loadStatus;
  logic csFall, sckRise, sckFall;

  assign csFall  = csPrev & ~csS;
  assign sckRise = sckS & ~sckPrev & ~paused;
  assign sckFall = ~sckS & sckPrev & ~paused;

  always_comb begin
    ctl.clear  = csFall;
    ctl.sample = sckRise && (phase != PH_IDLE) && (phase != PH_SKIP);
    ctl.launch = sckFall && (phase == PH_RDDATA);
    ctl.loadTx = loadPend;
    ctl.txWord = loadStatus ? {{(BYTE_W-1){1'b0}}, wipBit}
                            : {{(BYTE_W-DATA_W){1'b0}}, rdData};
  end

  assign soOe = (phase == PH_RDDATA) && !paused;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      csPrev     <= 1'b0;
      sckPrev    <= 1'b0;
      paused     <= 1'b0;
      loadPend   <= 1'b0;
      loadStatus <= 1'b0;
      cmdValid   <= 1'b0;
      cmdOp      <= '0;
      cmdReg     <= '0;
      cmdPot     <= 1'b0;
      cmdData    <= '0;
      incStep    <= 1'b0;
      incUp      <= 1'b0;
    end else begin
      csPrev   <= csS;
      sckPrev  <= sckS;
      cmdValid <= 1'b0;
      incStep  <= 1'b0;
      loadPend <= 1'b0;
      if (csS) paused <= 1'b0;
      else if (!sckS) paused <= !holdS;

      if (csS) begin
        phase <= PH_IDLE;
      end else if (csFall) begin
        phase <= PH_ID;
      end else if (sckRise && phase == PH_STEP) begin
        incStep <= 1'b1;
        incUp   <= siS;
      end else if (sckRise && lastBit) begin
        case (phase)
          PH_ID: begin
            if (rxNext[7:2] == ID_TYPE && rxNext[1:0] == addrStrap) phase <= PH_INSTR;
            else phase <= PH_SKIP;
          end
          PH_INSTR: begin
            cmdOp  <= rxNext[7:4];
            cmdReg <= rxNext[3:2];
            cmdPot <= rxNext[0];
            phase  <= PH_SKIP;
            case (rxNext[7:4])
              OP_RD_WCR, OP_RD_DR: begin
                cmdValid   <= 1'b1;
                loadPend   <= 1'b1;
                loadStatus <= 1'b0;
                phase      <= PH_RDDATA;
              end
              OP_STATUS: begin
                loadPend   <= 1'b1;
                loadStatus <= 1'b1;
                phase      <= PH_RDDATA;
              end
              OP_WR_WCR, OP_WR_DR: phase <= PH_WRDATA;
              OP_DR2WCR, OP_ALL_DR2WCR: cmdValid <= 1'b1;
              OP_WCR2DR, OP_ALL_WCR2DR: cmdValid <= wrProtN;
              OP_STEP: phase <= PH_STEP;
              default: phase <= PH_SKIP;
            endcase
          end
          PH_WRDATA: begin
            cmdData  <= rxNext[DATA_W-1:0];
            cmdValid <= !(cmdOp == OP_WR_DR && !wrProtN);
            phase    <= PH_SKIP;
          end
          PH_RDDATA: phase <= PH_SKIP;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/potSpiDecoder.sv
module potSpiDecoder
  import potSpiPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              si,
  input  logic              holdN,
  input  logic [1:0]        addrStrap,
  input  logic              wrProtN,
  input  logic              wipBit,
  input  logic [DATA_W-1:0] rdData,
  output logic              soOut,
  output logic              soOe,
  output logic              cmdValid,
  output logic [3:0]        cmdOp,
  output logic [1:0]        cmdReg,
  output logic              cmdPot,
  output logic [DATA_W-1:0] cmdData,
  output logic              incStep,
  output logic              incUp
);
  logic [3:0] pinsS;
  pathCtl_t ctl;
  logic [BYTE_W-1:0] rxNext;
  logic lastBit;

  potSync #(.W(4), .STAGES(SYNC_STAGES), .INIT(4'b0001)) uSync (
    .clk(clk), .rstN(rstN), .d({csN, sck, si, holdN}), .q(pinsS)
  );

  potSpiCtrl uCtrl (
    .clk(clk), .rstN(rstN),
    .csS(pinsS[3]), .sckS(pinsS[2]), .siS(pinsS[1]), .holdS(pinsS[0]),
    .addrStrap(addrStrap), .wrProtN(wrProtN), .wipBit(wipBit), .rdData(rdData),
    .rxNext(rxNext), .lastBit(lastBit), .ctl(ctl), .soOe(soOe),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdReg(cmdReg), .cmdPot(cmdPot),
    .cmdData(cmdData), .incStep(incStep), .incUp(incUp)
  );

  potSpiPath uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .siBit(pinsS[1]),
    .rxNext(rxNext), .lastBit(lastBit), .soBit(soOut)
  );
endmodule

// File: rtl/potSpiChecker.sv
module potSpiChecker (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic       wrProtN,
  input logic       soOe,
  input logic       cmdValid,
  input logic [3:0] cmdOp,
  input logic       incStep
);
  AST_SO_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> !soOe); // R12

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cmdValid, incStep})); // R7

  AST_CMD_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid); // R3

  AST_NO_NV_WRITE_PROTECTED: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !$past(wrProtN)) |->
      !(cmdOp == 4'b1100 || cmdOp == 4'b1110 || cmdOp == 4'b1000)); // R8
endmodule

bind potSpiDecoder potSpiChecker uChk (
  .clk(clk), .rstN(rstN), .csN(csN), .wrProtN(wrProtN), .soOe(soOe),
  .cmdValid(cmdValid), .cmdOp(cmdOp), .incStep(incStep)
);

// File: tb/tb_potSpiDecoder.sv
module tb_potSpiDecoder;
  localparam int HALF = 8;
  localparam logic [1:0] STRAP = 2'b10;
  localparam logic [5:0] RDVAL = 6'h2D;
  localparam int NVEC = 16;
  // id[35:28] ins[27:20] dat[19:12] three[11] wpN[10] expStrobe[9] chkSo[8] expSo[7:0]
  localparam logic [35:0] VEC [NVEC] = '{
    {8'h52, 8'hD5, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00},
    {8'h52, 8'h18, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00},
    {8'h52, 8'hEC, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00},
    {8'h52, 8'hEC, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {8'h52, 8'h80, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00},
    {8'h52, 8'h84, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00},
    {8'h52, 8'hA1, 8'h3A, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00},
    {8'h52, 8'hC9, 8'h15, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00},
    {8'h52, 8'hC9, 8'h15, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00},
    {8'h52, 8'h90, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 8'h2D},
    {8'h52, 8'hBD, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 8'h2D},
    {8'h52, 8'h50, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1, 8'h01},
    {8'h53, 8'hD5, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
    {8'h72, 8'hD5, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
    {8'h52, 8'hF0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00},
    {8'h52, 8'hA1, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00}
  };

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b0, sck = 1'b0, si = 1'b0, holdN = 1'b1;
  logic wrProtN = 1'b1;
  logic soOut, soOe, cmdValid, cmdPot, incStep, incUp;
  logic [3:0] cmdOp;
  logic [1:0] cmdReg;
  logic [5:0] cmdData;
  int nChecks = 0, nFail = 0, nCmd = 0, nInc = 0, nUp = 0;
  bit done = 0;

  always #10 clk = ~clk;

  potSpiDecoder dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .holdN(holdN),
    .addrStrap(STRAP), .wrProtN(wrProtN), .wipBit(1'b1), .rdData(RDVAL),
    .soOut(soOut), .soOe(soOe), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdReg(cmdReg), .cmdPot(cmdPot), .cmdData(cmdData),
    .incStep(incStep), .incUp(incUp)
  );

  always @(posedge clk) begin
    if (cmdValid) nCmd <= nCmd + 1;
    if (incStep) begin
      nInc <= nInc + 1;
      if (incUp) nUp <= nUp + 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spiBit(input logic b, output logic got);
    si = b;
    waitClk(HALF);
    got = soOut;
    sck = 1'b1;
    waitClk(HALF);
    sck = 1'b0;
  endtask

  task automatic spiByte(input logic [7:0] b, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) spiBit(b[i], got[i]);
  endtask

  task automatic clearCounts();
    waitClk(2);
    nCmd = 0; nInc = 0; nUp = 0;
  endtask

  function automatic string reqOf(input logic [35:0] v);
    logic [3:0] op = v[27:24];
    if (v[35:28] != {6'b010100, STRAP}) return "R1";
    if (!v[11] && (op == 4'b1010 || op == 4'b1100)) return "R9";
    if (!v[10] && !v[9]) return "R8";
    case (op)
      4'b1101, 4'b0001, 4'b1110, 4'b1000: return "R3";
      4'b1010, 4'b1100: return "R4";
      4'b1001, 4'b1011: return "R5";
      4'b0101: return "R6";
      default: return "R12";
    endcase
  endfunction

  initial begin
    logic [7:0] got;
    logic b;
    waitClk(5);
    rstN = 1'b1;
    waitClk(4);
    // reset state: no strobes, serial output disabled (R12)
    chk("R12 reset soOe", soOe, 0);
    chk("R12 reset cmdValid", cmdValid, 0);
    // R11: chip select low since reset, a frame without a falling edge is ignored
    clearCounts();
    spiByte(8'h52, got);
    spiByte(8'hD5, got);
    waitClk(6);
    chk("R11 no frame before select edge", nCmd, 0);
    csN = 1'b1;
    waitClk(12);

    for (int k = 0; k < NVEC; k++) begin
      logic [35:0] v = VEC[k];
      string req = reqOf(v);
      clearCounts();
      wrProtN = v[10];
      csN = 1'b0;
      waitClk(6);
      spiByte(v[35:28], got);
      spiByte(v[27:20], got);
      if (v[11]) spiByte(v[19:12], got);
      waitClk(6);
      csN = 1'b1;
      waitClk(12);
      chk({req, " strobe count"}, nCmd, int'(v[9]));
      if (v[9]) begin
        chk("R2 opcode field", cmdOp, v[27:24]);
        chk("R2 register field", cmdReg, v[23:22]);
        chk("R2 pot field", cmdPot, v[20]);
        if (v[27:24] == 4'b1010 || v[27:24] == 4'b1100) chk("R4 write data", cmdData, v[17:12]);
      end
      if (v[8]) chk({req, " shifted byte"}, got, v[7:0]);
      chk("R12 soOe deselected", soOe, 0);
    end
    wrProtN = 1'b1;

    // R7: open-ended step stream, pattern 1 1 0 1 1 0
    clearCounts();
    csN = 1'b0;
    waitClk(6);
    spiByte(8'h52, got);
    spiByte(8'h21, got);
    spiBit(1'b1, b); spiBit(1'b1, b); spiBit(1'b0, b);
    spiBit(1'b1, b); spiBit(1'b1, b); spiBit(1'b0, b);
    waitClk(6);
    csN = 1'b1;
    waitClk(12);
    chk("R7 step count", nInc, 6);
    chk("R7 up count", nUp, 4);
    chk("R7 last direction down", incUp, 0);
    chk("R7 pot select", cmdPot, 1);
    chk("R7 no command strobe", nCmd, 0);

    // R10: pause in the middle of a read byte
    clearCounts();
    csN = 1'b0;
    waitClk(6);
    spiByte(8'h52, got);
    spiByte(8'h94, got);
    got = '0;
    for (int i = 7; i >= 5; i--) spiBit(1'b0, got[i]);
    holdN = 1'b0;
    waitClk(6);
    chk("R10 soOe low while paused", soOe, 0);
    sck = 1'b1; waitClk(HALF); sck = 1'b0; waitClk(HALF);
    sck = 1'b1; waitClk(HALF); sck = 1'b0; waitClk(HALF);
    holdN = 1'b1;
    waitClk(6);
    chk("R5 soOe high during read", soOe, 1);
    for (int i = 4; i >= 0; i--) spiBit(1'b0, got[i]);
    waitClk(6);
    csN = 1'b1;
    waitClk(12);
    chk("R10 byte intact across pause", got, {2'b00, RDVAL});
    chk("R10 single fetch strobe", nCmd, 1);

    // R9: select released in the middle of the instruction byte
    clearCounts();
    csN = 1'b0;
    waitClk(6);
    spiByte(8'h52, got);
    for (int i = 7; i >= 4; i--) spiBit(1'b1, b);
    csN = 1'b1;
    waitClk(12);
    chk("R9 partial instruction aborted", nCmd, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end
endmodule